// File: doc/BRIEF.md
# Trimmed-Mean Sensor Sample Filter

This block sits between a thermal sensing point's raw count stream and the logic that turns counts into temperature. It gathers a group of raw samples and emits one filtered value per group. A 3-bit mode sets the group size and picks one of three reductions. The first is a plain pass-through of one sample. The second is the mean of two samples. The third drops the largest and the smallest sample and takes the mean of what remains, and the group size is always chosen so that a power of two of samples is left.

Four sensing points share one 12-bit control word, and each point has its own mode field. The point index that comes with the first sample of a group selects the field. The mode and the point are then held for the whole group. The mean is formed as a running sum, less the tracked extremes, shifted right. No divider is used.

Top module: `trim_mean_filter`

## Requirements
- R1: Mode code 000 passes each sample through unchanged; every sample forms its own group.
- R2: Mode code 001 groups two samples and outputs floor((a+b)/2).
- R3: Mode code 010 groups four samples, drops one maximum and one minimum, and outputs the floor of the mean of the other two. When values tie, only one copy of the extreme is dropped.
- R4: Mode code 011 groups six samples, drops the extremes and outputs floor(sum of remaining four / 4).
- R5: Mode code 100 groups ten samples, drops the extremes and outputs floor(sum of remaining eight / 8).
- R6: Mode code 101 groups eighteen samples, drops the extremes and outputs floor(sum of remaining sixteen / 16).
- R7: The reserved mode codes 110 and 111 behave exactly as 000.
- R8: The mode for point p is read from control-word bits [3p+2:3p]. Mode and point are latched on the first sample of a group. Later changes to the control word or to the point index take effect only at the next group, and flt_point_o reports the latched point.
- R9: flt_valid_o is high for exactly the one clock that follows the last sample of a group, and it is low at all other times.
- R10: 24-bit samples at the full-scale value 0xFFFFFF, in every mode up to eighteen samples, give 0xFFFFFF with no wrap.
- R11: Reset clears flt_valid_o, flt_data_o, flt_point_o and any partly collected group.
- R12: Clocks with smp_valid_i low between the samples of a group do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_word_i | input | 12 | Four 3-bit mode fields, point p at bits [3p+2:3p] |
| smp_valid_i | input | 1 | Raw sample strobe |
| smp_data_i | input | 24 | Raw unsigned sample |
| smp_point_i | input | 2 | Sensing point of the sample |
| flt_valid_o | output | 1 | One-clock pulse with the filtered result |
| flt_data_o | output | 24 | Filtered value |
| flt_point_o | output | 2 | Sensing point the result belongs to |

## Verification
The hardest case to reach from the ports is a control-word or point change in the middle of a group. The block has to keep the latched mode, and the stimulus causes this by rewriting the word after the first sample of a four-sample group so that it would ask for pass-through, and it also changes the point index at the same time. Each test also sets the fields of the other points to the eighteen-sample mode. If the block decoded the wrong field, the pulse would not come on the expected sample. The stimulus also reaches the accumulator's full-scale bound with eighteen samples of 0xFFFFFF, and it applies a reset while a group is only partly collected.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic [4:0] cnt;    // samples per group
    logic       trim;   // drop max and min
    logic [2:0] shift;  // log2 of samples kept
  } grp_cfg_t;

  function automatic grp_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    grp_cfg_t c;
    case (m)
      3'b001:  c = '{cnt: 5'd2,  trim: 1'b0, shift: 3'd1};
      3'b010:  c = '{cnt: 5'd4,  trim: 1'b1, shift: 3'd1};
      3'b011:  c = '{cnt: 5'd6,  trim: 1'b1, shift: 3'd2};
      3'b100:  c = '{cnt: 5'd10, trim: 1'b1, shift: 3'd3};
      3'b101:  c = '{cnt: 5'd18, trim: 1'b1, shift: 3'd4};
      default: c = '{cnt: 5'd1,  trim: 1'b0, shift: 3'd0}; // 000, 110, 111
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tmf_mode_sel.sv
module tmf_mode_sel
  import tmf_pkg::*;
#(
  parameter int N_PT = 4,
  localparam int PT_W = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic [N_PT*MODE_W-1:0] mode_word_i,
  input  logic [PT_W-1:0]        point_i,
  output grp_cfg_t               cfg_o
);
  logic [MODE_W-1:0] field [N_PT];

  for (genvar p = 0; p < N_PT; p++) begin : g_field
    assign field[p] = mode_word_i[p*MODE_W +: MODE_W];
  end

  assign cfg_o = decode_mode(field[point_i]);
endmodule

// File: rtl/tmf_extrema.sv
module tmf_extrema #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o
);
  logic [DATA_W-1:0] max_q, min_q;

  assign max_o = (first_i || data_i > max_q) ? data_i : max_q;
  assign min_o = (first_i || data_i < min_q) ? data_i : min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      min_q <= '0;
    end else if (en_i) begin
      max_q <= max_o;
      min_q <= min_o;
    end
  end

  assert_extrema_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> max_q >= min_q);
endmodule

// File: rtl/tmf_accum.sv
module tmf_accum #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = DATA_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [ACC_W-1:0] acc_q;

  assign sum_o = (first_i ? '0 : acc_q) + ACC_W'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end

  // running sum only grows inside a group
  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !first_i) |-> sum_o >= acc_q);
endmodule

// File: rtl/trim_mean_filter.sv
module trim_mean_filter
  import tmf_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int N_PT    = 4,
  parameter int MAX_GRP = 18,
  localparam int PT_W   = (N_PT > 1) ? $clog2(N_PT) : 1,
  localparam int ACC_W  = DATA_W + $clog2(MAX_GRP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PT*MODE_W-1:0] mode_word_i,
  input  logic                   smp_valid_i,
  input  logic [DATA_W-1:0]      smp_data_i,
  input  logic [PT_W-1:0]        smp_point_i,
  output logic                   flt_valid_o,
  output logic [DATA_W-1:0]      flt_data_o,
  output logic [PT_W-1:0]        flt_point_o
);
  grp_cfg_t          cfg_new, cfg_q, cfg_cur;
  logic              busy_q, first, last;
  logic [4:0]        cnt_q, cnt_cur;
  logic [PT_W-1:0]   pt_q, pt_cur;
  logic [DATA_W-1:0] max_n, min_n;
  logic [ACC_W-1:0]  sum_n, trimmed, extremes, result;

  tmf_mode_sel #(.N_PT(N_PT)) u_sel (
    .mode_word_i(mode_word_i),
    .point_i    (smp_point_i),
    .cfg_o      (cfg_new)
  );

  assign first   = !busy_q;
  assign cfg_cur = first ? cfg_new : cfg_q;
  assign pt_cur  = first ? smp_point_i : pt_q;
  assign cnt_cur = first ? 5'd0 : cnt_q;
  assign last    = smp_valid_i && (cnt_cur + 5'd1 == cfg_cur.cnt);

  tmf_extrema #(.DATA_W(DATA_W)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_valid_i),
    .first_i(first),
    .data_i (smp_data_i),
    .max_o  (max_n),
    .min_o  (min_n)
  );

  tmf_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_valid_i),
    .first_i(first),
    .data_i (smp_data_i),
    .sum_o  (sum_n)
  );

  assign extremes = cfg_cur.trim ? (ACC_W'(max_n) + ACC_W'(min_n)) : '0;
  assign trimmed  = sum_n - extremes;
  assign result   = trimmed >> cfg_cur.shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      pt_q   <= '0;
    end else if (smp_valid_i) begin
      if (first) begin
        cfg_q <= cfg_new;
        pt_q  <= smp_point_i;
      end
      busy_q <= !last;
      cnt_q  <= last ? 5'd0 : cnt_cur + 5'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_valid_o <= 1'b0;
      flt_data_o  <= '0;
      flt_point_o <= '0;
    end else begin
      flt_valid_o <= last;
      if (last) begin
        flt_data_o  <= result[DATA_W-1:0];
        flt_point_o <= pt_cur;
      end
    end
  end

  assert_pulse_after_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o |-> $past(smp_valid_i));
  assert_cnt_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != 5'd0 && cnt_q < cfg_q.cnt));
  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(cfg_q) && $stable(pt_q)));
  assert_result_fits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> (result >> DATA_W) == '0);
endmodule

// File: tb/trim_mean_filter_tb.sv
`timescale 1ns/1ps
module trim_mean_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mode_word = '0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic [1:0]  smp_point = '0;
  logic        flt_valid;
  logic [23:0] flt_data;
  logic [1:0]  flt_point;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [23:0] grp [18];
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  trim_mean_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_word_i(mode_word),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_point_i(smp_point),
    .flt_valid_o(flt_valid), .flt_data_o(flt_data), .flt_point_o(flt_point)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  pt;
    logic [2:0]  n;
    logic [23:0] s0, s1, s2, s3;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 3'd1, 24'h123456, 24'd0, 24'd0, 24'd0, 24'h123456},  // R1
    '{3'd1, 2'd1, 3'd2, 24'd10, 24'd13, 24'd0, 24'd0, 24'd11},           // R2
    '{3'd2, 2'd2, 3'd4, 24'd5, 24'd100, 24'd7, 24'd1, 24'd6},            // R3
    '{3'd2, 2'd3, 3'd4, 24'd50, 24'd50, 24'd50, 24'd50, 24'd50},         // R3
    '{3'd2, 2'd0, 3'd4, 24'd9, 24'd9, 24'd9, 24'd2, 24'd9},              // R3 tie
    '{3'd2, 2'd1, 3'd4, 24'd1, 24'd2, 24'd3, 24'd4, 24'd2},              // R3 floor
    '{3'd1, 2'd0, 3'd2, 24'hFFFFFF, 24'hFFFFFF, 24'd0, 24'd0, 24'hFFFFFF}, // R10
    '{3'd6, 2'd1, 3'd1, 24'hABCDEF, 24'd0, 24'd0, 24'd0, 24'hABCDEF},   // R7
    '{3'd7, 2'd2, 3'd1, 24'd7, 24'd0, 24'd0, 24'd0, 24'd7}               // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // other points' fields set to 101 so a wrong field pick shows up (R8)
  function automatic logic [11:0] word_for(input logic [2:0] m, input logic [1:0] p);
    logic [11:0] w = {4{3'b101}};
    w[p*3 +: 3] = m;
    return w;
  endfunction

  function automatic logic [23:0] model(input int n);
    logic [31:0] s = 0;
    logic [23:0] mx = grp[0], mn = grp[0];
    int keep;
    for (int i = 0; i < n; i++) begin
      s += grp[i];
      if (grp[i] > mx) mx = grp[i];
      if (grp[i] < mn) mn = grp[i];
    end
    keep = n;
    if (n > 2) begin
      s = s - mx - mn;
      keep = n - 2;
    end
    return 24'(s >> $clog2(keep));
  endfunction

  task automatic push(input logic [23:0] d, input logic [1:0] p);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    smp_point = p;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run_group(input logic [2:0] m, input logic [1:0] p, input int n,
                           input bit gap, input logic [23:0] exp, input string req);
    mode_word = word_for(m, p);
    for (int i = 0; i < n; i++) begin
      push(grp[i], p);
      if (i < n - 1) begin
        check(flt_valid == 1'b0, req, flt_valid, 0);
        if (gap) begin
          idle();
          @(posedge clk); #2;
          check(flt_valid == 1'b0, "R12", flt_valid, 0);
        end
      end else begin
        check(flt_valid == 1'b1, req, flt_valid, 1);
        check(flt_data == exp, req, flt_data, exp);
        check(flt_point == p, "R8", flt_point, p);
      end
    end
    idle();
    @(posedge clk); #2;
    check(flt_valid == 1'b0, "R9", flt_valid, 0);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      grp[i] = lcg[31:8];
    end
  endtask

  initial begin
    #3;
    check(flt_valid == 1'b0 && flt_data == 0 && flt_point == 0, "R11", {flt_valid, flt_data}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      grp[0] = VEC[v].s0; grp[1] = VEC[v].s1; grp[2] = VEC[v].s2; grp[3] = VEC[v].s3;
      run_group(VEC[v].mode, VEC[v].pt, int'(VEC[v].n), 1'b0, VEC[v].exp, "R1-table");
    end

    fill_rand(6);  run_group(3'd3, 2'd2, 6,  1'b0, model(6),  "R4");
    fill_rand(10); run_group(3'd4, 2'd3, 10, 1'b0, model(10), "R5");
    fill_rand(18); run_group(3'd5, 2'd0, 18, 1'b0, model(18), "R6");
    fill_rand(18); run_group(3'd5, 2'd1, 18, 1'b1, model(18), "R12");
    fill_rand(4);  run_group(3'd2, 2'd3, 4,  1'b1, model(4),  "R12");

    for (int i = 0; i < 18; i++) grp[i] = 24'hFFFFFF;
    run_group(3'd5, 2'd2, 18, 1'b0, 24'hFFFFFF, "R10");
    run_group(3'd4, 2'd1, 10, 1'b0, 24'hFFFFFF, "R10");

    // R8: word and point change after the first sample of a four-sample group
    grp[0] = 24'd40; grp[1] = 24'd1000; grp[2] = 24'd20; grp[3] = 24'd3;
    mode_word = word_for(3'd2, 2'd1);
    push(grp[0], 2'd1);
    check(flt_valid == 1'b0, "R8", flt_valid, 0);
    mode_word = 12'h000;
    for (int i = 1; i < 4; i++) begin
      push(grp[i], 2'd3);
      check(flt_valid == (i == 3), "R8", flt_valid, (i == 3));
    end
    check(flt_data == 24'd30 && flt_point == 2'd1, "R8", {flt_point, flt_data}, {2'd1, 24'd30});
    idle();

    // R11: reset in mid-group discards partial state
    mode_word = word_for(3'd1, 2'd0);
    push(24'd500, 2'd0);
    idle();
    rst_n = 1'b0;
    #2;
    check(flt_valid == 1'b0 && flt_data == 0, "R11", {flt_valid, flt_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    grp[0] = 24'd77;
    run_group(3'd0, 2'd0, 1, 1'b0, 24'd77, "R11");

    // R1: back-to-back single samples give one pulse each
    mode_word = word_for(3'd0, 2'd2);
    for (int i = 0; i < 3; i++) begin
      push(24'(i * 3 + 1), 2'd2);
      check(flt_valid == 1'b1 && flt_data == 24'(i * 3 + 1), "R1", flt_data, i * 3 + 1);
    end
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule